// File: doc/BRIEF.md
# Multiplexed LCD Waveform Sequencer

This block generates the time-multiplexed drive pattern for a passive LCD panel with up to four common lines and thirty-two segment lines. It walks through the active commons one at a time, advancing once per frame-rate tick (nominally 256 Hz). For each common it fetches that common's 32-bit row from an external display memory through a read port. It then produces one small level code per common line and one per segment line. An external resistor ladder or DAC turns each code into a voltage. The block does not generate any analog levels itself.

The bias (one half or one third) and the number of scanned commons (two, three or four) are inputs that can change at runtime. After each complete pass over the active commons the drive polarity is inverted, so every pixel sees zero average DC. While the display enable is low, every line is parked at ground and the scan restarts from the first common in positive polarity.

Top module: `lcd_mux_seq`

## Requirements
- R1: While `rst` is high and on the first cycles after it, `rd_com` is 0 and every common and segment code is ground (code 0).
- R2: `com_cnt_sel` picks the number of scanned commons: 00 gives 2, 01 gives 3, 10 gives 4, and 11 is treated as 4. Each `frame_tick` moves the scan to the next common in ascending order, wrapping to common 0 after the last active one.
- R3: Each time the scan wraps from the last active common back to common 0, the polarity inverts. It stays unchanged on every other step.
- R4: Level codes are 0 = ground, 1 = one third, 2 = one half, 3 = two thirds, 4 = full scale. The selected common drives full scale in positive polarity and ground in negative polarity. Every other common, including those past the active count, drives 2 under half bias. Under third bias it drives 1 in positive polarity and 3 in negative polarity.
- R5: Segment s uses bit s of the row that `rd_bits` returns for the common on `rd_com` (bit 1 means lit). A lit segment drives ground in positive polarity and full scale in negative polarity. An unlit segment drives 2 under half bias. Under third bias it drives 3 in positive polarity and 1 in negative polarity.
- R6: A clock edge with `lcd_en` low drives all line codes to 0 and returns the scan to common 0 in positive polarity. A `frame_tick` that arrives while disabled has no effect.
- R7: `rd_com` shows the current scan index and changes on the edge that samples a tick. The line codes reflect that index, its memory row and the polarity one clock later.
- R8: If the common count is reduced so that the current index is at or beyond the new last common, the next tick wraps to common 0 and inverts the polarity.
- R9: While enabled, exactly one common line carries a select level (ground or full scale).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_tick | input | 1 | One-cycle pulse per scan step (frame-rate tick) |
| lcd_en | input | 1 | Display enable; low blanks every line |
| bias_third | input | 1 | 1 selects one-third bias, 0 selects one-half bias |
| com_cnt_sel | input | 2 | Active common count code |
| rd_com | output | 2 | Display memory row (common index) being read |
| rd_bits | input | 32 | Row data returned for `rd_com`, bit s = segment s |
| com_lvl | output | 12 | Level code of common c in bits [3c+2:3c] |
| seg_lvl | output | 96 | Level code of segment s in bits [3s+2:3s] |

## Verification
The assertions assume that `rd_bits` is a combinational function of `rd_com`, settling within the same cycle, and that `frame_tick` is a single-cycle pulse. They also assume configuration inputs change only at negative clock edges. The bench models the display memory as an array indexed directly by `rd_com`. It drives every input, including ticks and configuration, at the falling edge and holds each tick high for exactly one cycle, so the design only ever sees inputs that meet these assumptions. Configuration changes happen either while the display is blanked or between ticks, which covers the shrink-while-scanning case without ever presenting an input that changes mid-cycle.

// File: rtl/lcdseq_pkg.sv
package lcdseq_pkg;

    localparam int LVL_W = 3;

    // Drive level codes handed to the external ladder
    typedef enum logic [LVL_W-1:0] {
        LV_GND      = 3'd0,
        LV_THIRD    = 3'd1,
        LV_HALF     = 3'd2,
        LV_TWOTHIRD = 3'd3,
        LV_FULL     = 3'd4
    } lvl_e;

    // Per-cycle drive context shared by the line drivers
    typedef struct packed {
        logic on;     // display enabled
        logic neg;    // negative polarity half of the waveform
        logic third;  // one-third bias when set
    } phase_t;

    // Last active common index for a count code, limited to the array size
    function automatic int last_common(input logic [1:0] cnt_sel, input int num_com);
        int n;
        case (cnt_sel)
            2'b00:   n = 1;
            2'b01:   n = 2;
            default: n = 3;
        endcase
        if (n > num_com - 1) n = num_com - 1;
        return n;
    endfunction

    function automatic lvl_e com_level(input logic sel, input phase_t ph);
        lvl_e v;
        if (!ph.on)        v = LV_GND;
        else if (sel)      v = ph.neg ? LV_GND : LV_FULL;
        else if (ph.third) v = ph.neg ? LV_TWOTHIRD : LV_THIRD;
        else               v = LV_HALF;
        return v;
    endfunction

    function automatic lvl_e seg_level(input logic lit, input phase_t ph);
        lvl_e v;
        if (!ph.on)        v = LV_GND;
        else if (lit)      v = ph.neg ? LV_FULL : LV_GND;
        else if (ph.third) v = ph.neg ? LV_THIRD : LV_TWOTHIRD;
        else               v = LV_HALF;
        return v;
    endfunction

endpackage

// File: rtl/lcdseq_scan.sv
module lcdseq_scan
    import lcdseq_pkg::*;
#(
    parameter int NUM_COM = 4,
    localparam int IDX_W  = (NUM_COM > 1) ? $clog2(NUM_COM) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             tick,
    input  logic [1:0]       cnt_sel,
    output logic [IDX_W-1:0] idx_o,
    output logic             neg_o
);

    logic [IDX_W-1:0] idx_q;
    logic             neg_q;
    logic [IDX_W-1:0] last;

    assign last = IDX_W'(last_common(cnt_sel, NUM_COM));

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            idx_q <= '0;
            neg_q <= 1'b0;
        end else if (tick) begin
            if (idx_q >= last) begin
                idx_q <= '0;
                neg_q <= ~neg_q;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    assign idx_o = idx_q;
    assign neg_o = neg_q;

    // R3
    wrap_flip_chk: assert property (@(posedge clk) disable iff (rst)
        (en && tick && idx_q >= last) |=> (neg_q != $past(neg_q)) && (idx_q == '0));

    // R2
    step_up_chk: assert property (@(posedge clk) disable iff (rst)
        (en && tick && idx_q < last) |=> (idx_q == IDX_W'($past(idx_q) + 1'b1)) && $stable(neg_q));

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !tick) |=> $stable(idx_q) && $stable(neg_q));

    // R6
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> (idx_q == '0) && !neg_q);

endmodule

// File: rtl/lcdseq_com_drv.sv
module lcdseq_com_drv
    import lcdseq_pkg::*;
#(
    parameter int NUM_COM = 4,
    localparam int IDX_W  = (NUM_COM > 1) ? $clog2(NUM_COM) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  phase_t                   ph,
    input  logic [IDX_W-1:0]         idx,
    output logic [NUM_COM*LVL_W-1:0] com_lvl
);

    lvl_e           lvl_q [NUM_COM];
    logic [NUM_COM-1:0] is_sel;
    logic           en_q;

    for (genvar c = 0; c < NUM_COM; c++) begin : g_com
        always_ff @(posedge clk) begin
            if (rst) lvl_q[c] <= LV_GND;
            else     lvl_q[c] <= com_level(idx == IDX_W'(c), ph);
        end
        assign com_lvl[c*LVL_W +: LVL_W] = lvl_q[c];
        assign is_sel[c] = (lvl_q[c] == LV_FULL) || (lvl_q[c] == LV_GND);
    end

    always_ff @(posedge clk) begin
        if (rst) en_q <= 1'b0;
        else     en_q <= ph.on;
    end

    // R9
    one_select_chk: assert property (@(posedge clk) disable iff (rst)
        en_q |-> ($countones(is_sel) == 1));

endmodule

// File: rtl/lcdseq_seg_drv.sv
module lcdseq_seg_drv
    import lcdseq_pkg::*;
#(
    parameter int NUM_SEG = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  phase_t                   ph,
    input  logic [NUM_SEG-1:0]       row_bits,
    output logic [NUM_SEG*LVL_W-1:0] seg_lvl
);

    lvl_e lvl_q [NUM_SEG];
    logic en_q;

    for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
        always_ff @(posedge clk) begin
            if (rst) lvl_q[s] <= LV_GND;
            else     lvl_q[s] <= seg_level(row_bits[s], ph);
        end
        assign seg_lvl[s*LVL_W +: LVL_W] = lvl_q[s];
    end

    always_ff @(posedge clk) begin
        if (rst) en_q <= 1'b0;
        else     en_q <= ph.on;
    end

    // R6
    seg_blank_chk: assert property (@(posedge clk) disable iff (rst)
        !en_q |-> (seg_lvl == '0));

endmodule

// File: rtl/lcd_mux_seq.sv
module lcd_mux_seq
    import lcdseq_pkg::*;
#(
    parameter int NUM_COM = 4,
    parameter int NUM_SEG = 32,
    localparam int IDX_W  = (NUM_COM > 1) ? $clog2(NUM_COM) : 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       frame_tick,
    input  logic                       lcd_en,
    input  logic                       bias_third,
    input  logic [1:0]                 com_cnt_sel,
    output logic [IDX_W-1:0]           rd_com,
    input  logic [NUM_SEG-1:0]         rd_bits,
    output logic [NUM_COM*LVL_W-1:0]   com_lvl,
    output logic [NUM_SEG*LVL_W-1:0]   seg_lvl
);

    logic [IDX_W-1:0] scan_idx;
    logic             scan_neg;
    phase_t           ph;

    lcdseq_scan #(.NUM_COM(NUM_COM)) scan_i (
        .clk     (clk),
        .rst     (rst),
        .en      (lcd_en),
        .tick    (frame_tick),
        .cnt_sel (com_cnt_sel),
        .idx_o   (scan_idx),
        .neg_o   (scan_neg)
    );

    assign ph.on    = lcd_en;
    assign ph.neg   = scan_neg;
    assign ph.third = bias_third;
    assign rd_com   = scan_idx;

    lcdseq_com_drv #(.NUM_COM(NUM_COM)) com_i (
        .clk     (clk),
        .rst     (rst),
        .ph      (ph),
        .idx     (scan_idx),
        .com_lvl (com_lvl)
    );

    lcdseq_seg_drv #(.NUM_SEG(NUM_SEG)) seg_i (
        .clk      (clk),
        .rst      (rst),
        .ph       (ph),
        .row_bits (rd_bits),
        .seg_lvl  (seg_lvl)
    );

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        $past(rst) |-> (com_lvl == '0) && (seg_lvl == '0) && (rd_com == '0));

endmodule

// File: tb/lcd_mux_seq_tb_top.sv
`timescale 1ns/1ps
module lcd_mux_seq_tb_top;

    localparam int NC = 4;
    localparam int NS = 32;

    logic            clk = 1'b0;
    logic            rst;
    logic            frame_tick;
    logic            lcd_en;
    logic            bias_third;
    logic [1:0]      com_cnt_sel;
    logic [1:0]      rd_com;
    logic [NS-1:0]   rd_bits;
    logic [NC*3-1:0] com_lvl;
    logic [NS*3-1:0] seg_lvl;

    logic [NS-1:0] mem [NC];
    int  tests = 0;
    int  fails = 0;
    bit  done  = 0;
    int  e_idx;
    bit  e_neg;

    always #2 clk = ~clk;

    assign rd_bits = mem[rd_com];

    lcd_mux_seq dut_i (
        .clk(clk), .rst(rst), .frame_tick(frame_tick), .lcd_en(lcd_en),
        .bias_third(bias_third), .com_cnt_sel(com_cnt_sel), .rd_com(rd_com),
        .rd_bits(rd_bits), .com_lvl(com_lvl), .seg_lvl(seg_lvl)
    );

    // voltage in sixths of full scale -> level code
    function automatic logic [2:0] code_of(input int sixths);
        case (sixths)
            0: return 3'd0;
            2: return 3'd1;
            3: return 3'd2;
            4: return 3'd3;
            default: return 3'd4;
        endcase
    endfunction

    function automatic int last_of(input logic [1:0] sel);
        return (sel == 2'b00) ? 1 : (sel == 2'b01) ? 2 : 3;
    endfunction

    task automatic check(input string req, input bit blank);
        logic [NC*3-1:0] ec;
        logic [NS*3-1:0] es;
        int v;
        for (int c = 0; c < NC; c++) begin
            if (blank)           v = 0;
            else if (c == e_idx) v = e_neg ? 0 : 6;
            else if (bias_third) v = e_neg ? 4 : 2;
            else                 v = 3;
            ec[c*3 +: 3] = code_of(v);
        end
        for (int s = 0; s < NS; s++) begin
            if (blank)                  v = 0;
            else if (mem[e_idx][s])     v = e_neg ? 6 : 0;
            else if (bias_third)        v = e_neg ? 2 : 4;
            else                        v = 3;
            es[s*3 +: 3] = code_of(v);
        end
        tests++;
        if (com_lvl !== ec || seg_lvl !== es || rd_com !== 2'(e_idx)) begin
            fails++;
            $display("FAIL %s: com=%h seg=%h idx=%0d expected com=%h seg=%h idx=%0d",
                     req, com_lvl, seg_lvl, rd_com, ec, es, e_idx);
        end
    endtask

    task automatic step(input string req);
        frame_tick = 1'b1;
        @(negedge clk);
        frame_tick = 1'b0;
        if (e_idx >= last_of(com_cnt_sel)) begin
            e_idx = 0;
            e_neg = ~e_neg;
        end else begin
            e_idx++;
        end
        @(negedge clk);
        check(req, 1'b0);
    endtask

    task automatic blank_and_config(input bit third, input logic [1:0] sel, input int pat);
        lcd_en = 1'b0;
        @(negedge clk);
        e_idx = 0; e_neg = 1'b0;
        check("R6 blank", 1'b1);
        bias_third  = third;
        com_cnt_sel = sel;
        for (int c = 0; c < NC; c++) mem[c] = 32'h9E3779B9 * (c + 1 + pat);
        lcd_en = 1'b1;
        @(negedge clk);
        check("R7 restart", 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; frame_tick = 1'b0; lcd_en = 1'b0;
        bias_third = 1'b0; com_cnt_sel = 2'b10;
        for (int c = 0; c < NC; c++) mem[c] = '0;
        e_idx = 0; e_neg = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 in reset", 1'b1);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset", 1'b1);

        // R2 R3 R4 R5: sweep bias x count code, several frames each
        for (int b = 0; b < 2; b++) begin
            for (int sel = 0; sel < 4; sel++) begin
                blank_and_config(b[0], 2'(sel), b * 4 + sel);
                for (int k = 0; k < 2 * (last_of(2'(sel)) + 1) + 1; k++)
                    step(sel == 3 ? "R2 code11" : "R3/R4/R5 scan");
            end
        end

        // R8: shrink count while at common 3
        blank_and_config(1'b1, 2'b10, 9);
        repeat (3) step("R2 to common 3");
        com_cnt_sel = 2'b00;
        step("R8 shrink wrap");
        step("R8 after shrink");
        step("R8 second frame");

        // R6: tick while disabled is ignored, restart at common 0 positive
        blank_and_config(1'b0, 2'b01, 11);
        step("R2 step");
        lcd_en = 1'b0;
        frame_tick = 1'b1;
        @(negedge clk);
        frame_tick = 1'b0;
        e_idx = 0; e_neg = 1'b0;
        check("R6 tick while off", 1'b1);
        lcd_en = 1'b1;
        @(negedge clk);
        check("R6 resume at common 0", 1'b0);

        // R5: all-lit and all-dark rows under both polarities
        blank_and_config(1'b1, 2'b10, 0);
        for (int c = 0; c < NC; c++) mem[c] = (c % 2 == 0) ? '1 : '0;
        @(negedge clk);
        check("R5 solid rows", 1'b0);
        for (int k = 0; k < 8; k++) step("R5 solid rows");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule